// File: doc/BRIEF.md
# Serial-Chain Shared Bus Arbiter

This block decides which of several bus masters owns a shared bus. The masters form a serial chain that starts at the arbiter. Each master has a request flag. The OR of all flags drives one shared bus-request line. When that line is high and the bus is free, the arbiter raises a single grant. A grant token enters the chain at master 0 and moves one position per clock through registered pass-through cells. A master with a pending request keeps the token and takes the bus. A master with no pending request hands the token to the next position. Because of this, chain position alone sets the priority.

An owning master drives the shared bus-busy line. It keeps ownership until its done input is pulsed. The arbiter holds its grant until it sees bus-busy, then withdraws the grant. It issues no new grant while the bus is busy. Masters that lose a contest keep their request flags and compete again once the bus is free.

Top module: `dc_bus_arbiter`

## Requirements
- R1: A one-cycle pulse on `req_i[k]` sets master k's request flag on the next clock edge. The flag stays set until master k releases the bus. `bus_req_o` is the OR of all request flags, so it is high from the cycle after a request pulse.
- R2: When `bus_req_o` is high and `bus_busy_o` is low, `grant_o` rises on the next clock edge. It stays high until it samples `bus_busy_o` high, and it is low in the cycle after any cycle in which `bus_busy_o` is high.
- R3: Each chain position adds one register stage. Master k's `taken_o[k]` rises exactly k+1 cycles after `grant_o` rises, provided master k is the winner.
- R4: A master with no pending request passes the token on. A master with a pending request keeps the token, so no master further down the chain receives it.
- R5: When several masters have pending requests as a grant starts, the master with the lowest index (closest to the arbiter) wins.
- R6: At most one bit of `taken_o` is ever high. `bus_busy_o` is high exactly when some master owns the bus.
- R7: A pulse on `done_i[k]` while master k owns the bus has these effects on the next edge:
  - `taken_o[k]` and `bus_busy_o` drop;
  - master k's request flag clears;
  - pending requests from other masters then start a new grant.
- R8: With no pending request, `grant_o`, `bus_busy_o` and `taken_o` stay low.
- R9: A `done_i[k]` pulse on a master that does not own the bus has no effect. The owner, `bus_busy_o` and `bus_req_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NM | Per-master request pulse; bit 0 is closest to the arbiter |
| done_i | input | NM | Per-master end-of-ownership pulse |
| taken_o | output | NM | Per-master flag: this master holds the bus |
| bus_req_o | output | 1 | Shared bus-request line (OR of pending requests) |
| bus_busy_o | output | 1 | Shared bus-busy line |
| grant_o | output | 1 | Arbiter grant that enters the chain at master 0 |

## Verification
The properties assume that `done_i` is pulsed only for one cycle at a time. They also assume that a request pulse arrives only at a master that is not currently the owner, so an owner never re-requests while it holds the bus. The stimulus follows both rules. Every input is a single-cycle pulse driven between clock edges. The bench releases the bus only through the current owner's done line, except in the one scenario that deliberately pulses done on a non-owner.

// File: rtl/dc_arb_pkg.sv
package dc_arb_pkg;
  // Arbiter grant state: idle, or holding the grant until busy is seen
  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_GRANT = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dc_arb_core.sv
module dc_arb_core
  import dc_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_i,
  input  logic bus_busy_i,
  output logic grant_o,
  output logic token_o
);
  arb_state_e state_q;
  logic       grant_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ARB_IDLE;
      grant_prev_q <= 1'b0;
    end else begin
      grant_prev_q <= (state_q == ARB_GRANT);
      unique case (state_q)
        ARB_IDLE:  if (bus_req_i && !bus_busy_i) state_q <= ARB_GRANT;
        ARB_GRANT: if (bus_busy_i)               state_q <= ARB_IDLE;
        default:                                 state_q <= ARB_IDLE;
      endcase
    end
  end

  assign grant_o = (state_q == ARB_GRANT);
  // single-cycle token injected into the chain on the grant's leading edge
  assign token_o = grant_o && !grant_prev_q;
endmodule

// File: rtl/dc_chain_cell.sv
module dc_chain_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic done_i,
  input  logic tok_in_i,
  output logic tok_out_o,
  output logic own_o,
  output logic pend_o
);
  logic pend_q, own_q, tok_q;
  logic release_w;

  assign release_w = own_q && done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      own_q  <= 1'b0;
      tok_q  <= 1'b0;
    end else begin
      pend_q <= release_w ? 1'b0 : (pend_q || req_i);
      if (own_q) own_q <= !done_i;
      else       own_q <= tok_in_i && pend_q;
      // forward the token only when this master is not asking
      tok_q  <= tok_in_i && !pend_q;
    end
  end

  assign tok_out_o = tok_q;
  assign own_o     = own_q;
  assign pend_o    = pend_q;
endmodule

// File: rtl/dc_bus_arbiter.sv
module dc_bus_arbiter #(
  parameter int NM = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req_i,
  input  logic [NM-1:0] done_i,
  output logic [NM-1:0] taken_o,
  output logic          bus_req_o,
  output logic          bus_busy_o,
  output logic          grant_o
);
  localparam int LINKS = NM + 1;

  logic [LINKS-1:0] link_w;
  logic [NM-1:0]    pend_w;
  logic [NM-1:0]    own_w;
  logic             token_w;

  dc_arb_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req_i  (bus_req_o),
    .bus_busy_i (bus_busy_o),
    .grant_o    (grant_o),
    .token_o    (token_w)
  );

  assign link_w[0] = token_w;

  for (genvar k = 0; k < NM; k++) begin : g_cell
    dc_chain_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i[k]),
      .done_i    (done_i[k]),
      .tok_in_i  (link_w[k]),
      .tok_out_o (link_w[k+1]),
      .own_o     (own_w[k]),
      .pend_o    (pend_w[k])
    );
  end

  assign bus_req_o  = |pend_w;
  assign bus_busy_o = |own_w;
  assign taken_o    = own_w;
endmodule

// File: rtl/dc_bus_arbiter_chk.sv
module dc_bus_arbiter_chk #(
  parameter int NM = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] done_i,
  input logic [NM-1:0] taken_o,
  input logic          bus_req_o,
  input logic          bus_busy_o,
  input logic          grant_o
);
  p_one_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taken_o));

  p_busy_blocks_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy_o |=> !grant_o);

  p_idle_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req_o && !grant_o) |=> !grant_o);

  p_grant_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_busy_o && !grant_o) |=> grant_o);

  for (genvar k = 0; k < NM; k++) begin : g_own
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_o[k] && done_i[k]) |=> !taken_o[k]);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (taken_o[k] && !done_i[k]) |=> taken_o[k]);
  end
endmodule

bind dc_bus_arbiter dc_bus_arbiter_chk #(.NM(NM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_i     (done_i),
  .taken_o    (taken_o),
  .bus_req_o  (bus_req_o),
  .bus_busy_o (bus_busy_o),
  .grant_o    (grant_o)
);

// File: tb/dc_bus_arbiter_tb.sv
module dc_bus_arbiter_tb;
  localparam int NM = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM-1:0] req_i = '0;
  logic [NM-1:0] done_i = '0;
  logic [NM-1:0] taken_o;
  logic          bus_req_o, bus_busy_o, grant_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dc_bus_arbiter #(.NM(NM)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i),
    .taken_o(taken_o), .bus_req_o(bus_req_o), .bus_busy_o(bus_busy_o),
    .grant_o(grant_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [NM-1:0] m);
    req_i = m; @(negedge clk); req_i = '0;
  endtask

  task automatic pulse_done(input logic [NM-1:0] m);
    done_i = m; @(negedge clk); done_i = '0;
  endtask

  // Wait for grant rise, then count cycles to the owner appearing
  task automatic wait_owner(input int who, input string tag);
    int lat = 0;
    int g = 0;
    while (!grant_o && g < 20) begin @(negedge clk); g++; end
    while (taken_o == '0 && lat < 20) begin @(negedge clk); lat++; end
    check(taken_o == NM'(1 << who), {tag, " winner"}, int'(taken_o), 1 << who);
    check(lat == who + 1, {tag, " latency R3"}, lat, who + 1);
    check(bus_busy_o == 1'b1, {tag, " busy R6"}, int'(bus_busy_o), 1);
    @(negedge clk);
    check(grant_o == 1'b0, {tag, " grant drop R2"}, int'(grant_o), 0);
  endtask

  task automatic t_reset();
    check(taken_o == '0, "R8 reset taken", int'(taken_o), 0);
    check(!bus_busy_o && !grant_o && !bus_req_o, "R8 reset lines",
          int'({bus_req_o, bus_busy_o, grant_o}), 0);
    cyc(6);
    check(!grant_o && taken_o == '0, "R8 idle stays quiet",
          int'({grant_o, taken_o}), 0);
  endtask

  task automatic t_single(input int who);
    pulse_req(NM'(1 << who));
    check(bus_req_o == 1'b1, "R1 bus request up", int'(bus_req_o), 1);
    check(grant_o == 1'b0, "R2 grant not yet", int'(grant_o), 0);
    @(negedge clk);
    check(grant_o == 1'b1, "R2 grant next cycle", int'(grant_o), 1);
    wait_owner(who, "R4 pass-through");
    pulse_done(NM'(1 << who));
    check(taken_o == '0 && !bus_busy_o, "R7 release", int'(taken_o), 0);
    check(bus_req_o == 1'b0, "R7 request cleared", int'(bus_req_o), 0);
    cyc(3);
    check(!grant_o, "R8 no regrant", int'(grant_o), 0);
  endtask

  task automatic t_contest();
    pulse_req(4'b1010);
    wait_owner(1, "R5 contest 1v3");
    pulse_done(4'b0010);
    check(bus_req_o == 1'b1, "R1 loser still pending", int'(bus_req_o), 1);
    wait_owner(3, "R7 loser served next");
    pulse_done(4'b1000);
    pulse_req(4'b1111);
    wait_owner(0, "R5 all request");
    pulse_done(4'b0001);
    wait_owner(1, "R5 order 1");
    pulse_done(4'b0010);
    wait_owner(2, "R5 order 2");
    pulse_done(4'b0100);
    wait_owner(3, "R5 order 3");
    pulse_done(4'b1000);
    cyc(2);
  endtask

  task automatic t_busy_block();
    pulse_req(4'b0100);
    wait_owner(2, "R4 owner 2");
    pulse_req(4'b0001);
    cyc(4);
    check(grant_o == 1'b0, "R2 no grant while busy", int'(grant_o), 0);
    check(taken_o == 4'b0100, "R6 owner kept", int'(taken_o), 4);
    pulse_done(4'b0001);
    check(taken_o == 4'b0100 && bus_busy_o, "R9 stray done ignored",
          int'(taken_o), 4);
    check(bus_req_o == 1'b1, "R9 request kept", int'(bus_req_o), 1);
    pulse_done(4'b0100);
    wait_owner(0, "R7 waiting master served");
    pulse_done(4'b0001);
    cyc(2);
  endtask

  initial begin
    fork
      begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int w = 0; w < NM; w++) t_single(w);
        t_contest();
        t_busy_block();
        finished = 1'b1;
      end
      begin
        cyc(5000);
        if (!finished) check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule